// File: doc/BRIEF.md
# Multiplexed LED Column Scan Driver

This block refreshes a bank of seven 8x8 LED modules by lighting one column of every module at a time. A host fills a 56-byte picture store through a simple write port, with one byte per module column. At the end of each scan slot the driver fetches the bytes for the next column of all seven modules and holds them in a shadow register. It then regroups the bits so that each of eight bus words carries the same bit position from every module.

Each slot opens with a blanking interval in which the module output-enable lines are held off. While the LEDs are dark, the eight shared bus pins act as a serial data and clock port for seven shift-register drivers, which are loaded in parallel. After the last word the same pins go back to driving the column lines, which are active low. The length of the blanking interval sets the brightness. It is derived from a percentage input, which the driver clamps so that the LEDs are never fully off and never fully on.

Top module: `led_colscan_driver`

## Requirements
- R1: While reset is asserted, and right after it, the picture store reads as all zeros, column 0 is selected, `blank_o` is 1, and `bus_o` is 8'h00.
- R2: A scan slot lasts exactly SLOT_CYCLES clock cycles, and `blank_o` rises on the first cycle of every slot.
- R3: In slot cycles 2j and 2j+1 (j = 0..7), the bus carries word 7-j, so words go out from bit position 7 down to 0. Bit 0 is 0 in the even cycle and 1 in the odd cycle, and bits 7..1 are the same in both cycles.
- R4: Word n has bit m+1 equal to bit n of the byte stored at address 8*m + c, where m is the module (0..6) and c is the column being shown.
- R5: From slot cycle 16 until the slot ends, the bus drives column c with exactly bit c low and all other bits high.
- R6: `blank_o` is 1 for the first (100 - d) * SLOT_CYCLES/100 cycles of a slot and 0 for the rest, where d is the clamped duty latched at the start of the slot. The blanking interval always covers the 17-cycle load window.
- R7: A duty input below 1 acts as 1, and a duty input above 99 acts as 99. A new duty value takes effect at the next slot boundary.
- R8: A write to an address of 56 or above changes nothing that is displayed.
- R9: A host write never changes the words of the slot in progress. It appears the next time its column is fetched.
- R10: The column advances by one each slot and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Picture store write strobe |
| wr_addr | input | 6 | Write address, module*8 + column |
| wr_data | input | 8 | Column byte to store |
| duty_pct | input | 7 | Requested brightness in percent |
| bus_o | output | 8 | Shared bus: serial data and clock during the load window, active-low column drive afterwards |
| blank_o | output | 1 | Output-enable PWM, 1 = module drivers off |

## Verification
The transposition is tried with three kinds of column data. All-ones and all-zeros bytes check the polarity of each lane. A byte with one bit walking across the modules catches a module-to-lane or bit-to-word swap that uniform data would hide. Address-hashed bytes catch a wrong column or stride in the store lookup. Duty values of 0, 1, 25, 50, 70, 99, 100 and 127 separate correct blanking lengths from clamping faults at both ends. Writes to the column being shown, together with out-of-range writes, tell whether the shadow register isolates a slot from host traffic and whether addresses alias into the store.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int PCT_MIN = 1;
  localparam int PCT_MAX = 99;

  function automatic logic [6:0] clamp_pct(input logic [6:0] raw);
    if (int'(raw) < PCT_MIN) return 7'(PCT_MIN);
    if (int'(raw) > PCT_MAX) return 7'(PCT_MAX);
    return raw;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int SLOT_CYCLES = 2000,
  parameter int COLS        = 8,
  localparam int CNT_W = $clog2(SLOT_CYCLES),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] col_nxt_o,
  output logic [COLS-1:0]  ring_o,
  output logic             slot_end_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] col_q, col_d, col_nxt;
  logic [COLS-1:0]  ring_q, ring_d;
  logic             slot_end;

  always_comb begin
    slot_end = (int'(cnt_q) == SLOT_CYCLES - 1);
    col_nxt  = (int'(col_q) == COLS - 1) ? '0 : col_q + 1'b1;
    cnt_d    = slot_end ? '0 : cnt_q + 1'b1;
    col_d    = slot_end ? col_nxt : col_q;
    ring_d   = slot_end ? {ring_q[COLS-2:0], ring_q[COLS-1]} : ring_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      col_q  <= '0;
      ring_q <= COLS'(1);
    end else begin
      cnt_q  <= cnt_d;
      col_q  <= col_d;
      ring_q <= ring_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign col_o      = col_q;
  assign col_nxt_o  = col_nxt;
  assign ring_o     = ring_q;
  assign slot_end_o = slot_end;

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (cnt_q == '0)); // R2
  AST_RING_TRACKS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ring_q == (COLS'(1) << col_q)); // R10
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (col_q == $past(col_nxt))); // R10
endmodule

// File: rtl/scan_mem.sv
module scan_mem #(
  parameter int MODULES = 7,
  parameter int COLS    = 8,
  parameter int W       = 8,
  localparam int DEPTH  = MODULES * COLS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int COL_W  = $clog2(COLS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [W-1:0]                 wr_data,
  input  logic [COL_W-1:0]             rd_col,
  output logic [MODULES-1:0][W-1:0]    rd_bytes
);
  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic                    wr_ok;

  always_comb begin
    wr_ok = wr_en && (int'(wr_addr) < DEPTH);
    mem_d = mem_q;
    if (wr_ok) mem_d[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (wr_ok) mem_q <= mem_d;
  end

  for (genvar m = 0; m < MODULES; m++) begin : g_rd
    assign rd_bytes[m] = mem_q[m * COLS + int'(rd_col)];
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= DEPTH) |=> $stable(mem_q)); // R8
endmodule

// File: rtl/scan_transpose.sv
module scan_transpose #(
  parameter int MODULES = 7,
  parameter int W       = 8,
  localparam int BUS_W  = MODULES + 1
) (
  input  logic [MODULES-1:0][W-1:0] bytes_i,
  output logic [W-1:0][BUS_W-1:0]   words_o
);
  for (genvar n = 0; n < W; n++) begin : g_word
    assign words_o[n][0] = 1'b0;
    for (genvar m = 0; m < MODULES; m++) begin : g_lane
      assign words_o[n][m+1] = bytes_i[m][n];
    end
  end
endmodule

// File: rtl/led_colscan_driver.sv
module led_colscan_driver #(
  parameter int SLOT_CYCLES = 2000,
  parameter int MODULES     = 7,
  parameter int COLS        = 8,
  parameter int W           = 8,
  localparam int DEPTH  = MODULES * COLS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BUS_W  = MODULES + 1,
  localparam int CNT_W  = $clog2(SLOT_CYCLES),
  localparam int COL_W  = $clog2(COLS),
  localparam int LW     = $clog2(W),
  localparam int PCT    = SLOT_CYCLES / 100,
  localparam int LOAD_CYC = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [6:0]        duty_pct,
  output logic [BUS_W-1:0]  bus_o,
  output logic              blank_o
);
  import led_scan_pkg::*;

  if (BUS_W != COLS) begin : g_bad_bus
    $error("bus width must equal column count");
  end
  if (PCT < LOAD_CYC + 1) begin : g_bad_slot
    $error("one percent of a slot must hold the load window");
  end

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [CNT_W-1:0]              cnt;
  logic [COL_W-1:0]              col, col_nxt;
  logic [COLS-1:0]               ring;
  logic                          slot_end;
  logic [MODULES-1:0][W-1:0]     fetch;
  logic [W-1:0][BUS_W-1:0]       words;
  logic [W-1:0][BUS_W-1:0]       sh_q, sh_d;
  logic [6:0]                    duty_q, duty_d;
  logic [CNT_W-1:0]              blank_len;
  logic [LW-1:0]                 widx;
  logic                          in_load;

  scan_timer #(.SLOT_CYCLES(SLOT_CYCLES), .COLS(COLS)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .cnt_o(cnt), .col_o(col),
    .col_nxt_o(col_nxt), .ring_o(ring), .slot_end_o(slot_end)
  );

  scan_mem #(.MODULES(MODULES), .COLS(COLS), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_col(col_nxt), .rd_bytes(fetch)
  );

  scan_transpose #(.MODULES(MODULES), .W(W)) u_xpose (
    .bytes_i(fetch), .words_o(words)
  );

  always_comb begin
    sh_d   = slot_end ? words : sh_q;
    duty_d = slot_end ? clamp_pct(duty_pct) : duty_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sh_q   <= '0;
      duty_q <= 7'(PCT_MIN);
    end else if (slot_end) begin
      sh_q   <= sh_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    blank_len = CNT_W'((100 - int'(duty_q)) * PCT);
    in_load   = (int'(cnt) < LOAD_CYC);
    widx      = LW'(W - 1) - cnt[LW:1];
    blank_o   = (cnt < blank_len);
    if (in_load) bus_o = sh_q[widx] | BUS_W'(cnt[0]);
    else         bus_o = ~ring;
  end

  AST_BLANK_COVERS_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (int'(cnt) <= LOAD_CYC) |-> blank_o); // R6
  AST_ONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_load |-> ($countones(bus_o) == COLS - 1)); // R5
  AST_CLK_RISE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_load && cnt[0]) |-> (bus_o[0] && bus_o[BUS_W-1:1] == $past(bus_o[BUS_W-1:1]))); // R3
  AST_DUTY_CLAMPED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (int'(duty_q) >= PCT_MIN && int'(duty_q) <= PCT_MAX)); // R7
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !slot_end |=> $stable(sh_q)); // R9
endmodule

// File: tb/led_colscan_driver_test.sv
module led_colscan_driver_test;
  localparam int SLOT = 1700;
  localparam int PCTC = SLOT / 100;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] duty_pct;
  logic [7:0] bus_o;
  logic       blank_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] model [56];
  logic [7:0] snap  [56];
  int ecol;
  int cur_bl;

  // {duty input, expected blank cycles for SLOT=1700, data pattern kind}
  localparam int VEC [8][3] = '{
    '{0,   1683, 0},
    '{1,   1683, 1},
    '{25,  1275, 2},
    '{50,  850,  3},
    '{99,  17,   4},
    '{100, 17,   1},
    '{127, 17,   3},
    '{70,  510,  2}
  };

  led_colscan_driver #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .duty_pct(duty_pct), .bus_o(bus_o), .blank_o(blank_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int kind, input int m, input int c);
    case (kind)
      0: return 8'hFF;
      1: return 8'h01 << m;
      2: return 8'h80 >> m;
      3: return 8'((m * 8 + c) * 59) ^ 8'h5A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_word(input int k);
    logic [7:0] w;
    int n;
    n = 7 - k / 2;
    w = 8'(k % 2);
    for (int m = 0; m < 7; m++) w[m+1] = snap[m*8 + ecol][n];
    return w;
  endfunction

  // Starts at the negedge of slot cycle 0; ends at cycle 0 of the next slot.
  task automatic run_slot(input int nduty, input int nbl, input int kind, input bit do_wr);
    logic [7:0] eb;
    for (int k = 0; k < SLOT; k++) begin
      if (k < 16) begin
        eb = exp_word(k);
        chk(bus_o == eb, "R3 R4 R8 R9 load word", bus_o, eb);
      end else begin
        eb = ~(8'h01 << ecol);
        chk(bus_o == eb, "R5 R10 column drive", bus_o, eb);
      end
      chk(blank_o == (k < cur_bl), "R2 R6 R7 blanking", {7'd0, blank_o}, {7'd0, k < cur_bl});
      if (do_wr && k >= 20 && k < 27) begin
        // R9: write the column on display; it must not show until its next turn
        wr_en = 1'b1;
        wr_addr = 6'((k - 20) * 8 + ecol);
        wr_data = pat(kind, k - 20, ecol);
        model[(k - 20) * 8 + ecol] = wr_data;
      end else if (do_wr && k == 27) begin
        // R8: out-of-range address, must alias nowhere
        wr_en = 1'b1;
        wr_addr = 6'(56 + ecol);
        wr_data = 8'hC3;
      end else begin
        wr_en = 1'b0;
      end
      if (k == SLOT - 1) begin
        duty_pct = 7'(nduty);
        for (int a = 0; a < 56; a++) snap[a] = model[a];
      end
      @(negedge clk);
    end
    cur_bl = nbl;
    ecol = (ecol + 1) % 8;
  endtask

  task automatic align();
    while (blank_o !== 1'b0) @(negedge clk);
    while (blank_o !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    duty_pct = 7'd50;
    for (int a = 0; a < 56; a++) begin model[a] = '0; snap[a] = '0; end
    repeat (4) @(negedge clk);
    chk(bus_o == 8'h00, "R1 reset bus", bus_o, 8'h00);
    chk(blank_o == 1'b1, "R1 reset blank", {7'd0, blank_o}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(blank_o == 1'b1, "R1 blank after release", {7'd0, blank_o}, 8'h01);
    align();
    ecol = 1;
    cur_bl = 850;
    for (int r = 0; r < 8; r++) run_slot(VEC[r][0], VEC[r][1], VEC[r][2], 1'b1);
    for (int s = 0; s < 9; s++) run_slot(70, 510, 0, 1'b0);

    // R1: asynchronous reset mid-frame clears store, column and duty
    @(posedge clk);
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk(bus_o == 8'h00, "R1 async reset bus", bus_o, 8'h00);
    chk(blank_o == 1'b1, "R1 async reset blank", {7'd0, blank_o}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 56; a++) begin model[a] = '0; snap[a] = '0; end
    align();
    ecol = 1;
    cur_bl = 510;
    run_slot(70, 510, 0, 1'b0);
    run_slot(70, 510, 0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule